// File: doc/BRIEF.md
# Descriptor-Driven Copy Engine with Inline CRC32

This block moves a run of 64-bit words from one region of memory to another under the control of a small descriptor held in that same memory. While the words stream past, a hardwired CRC32 unit folds each one into a running checksum within a single clock. That lets one pass over the data do three jobs: copy it, stamp a fresh CRC into the descriptor, or check the data against a CRC already stored there.

Software writes a five-word descriptor and pulses `start_i` with the descriptor's word address. The engine then works through four steps in order: it reads the descriptor, streams the data, settles the CRC, and writes a status word back into the descriptor. Mode bits in the descriptor select what happens.

- Check mode compares the computed CRC with the stored one.
- A no-write flag suppresses every destination write, so the engine only reads and checksums the data.
- An interrupt flag raises a sticky interrupt when a check fails.

Both memory ports use a valid/ready handshake and may stall for any number of cycles.

Top module: `crc_dma_engine`

## Requirements
- R1: The CRC is CRC32 with reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), a preset of 0xFFFFFFFF and a final inversion. Each 64-bit word is consumed byte 0 (bits 7:0) first, and each byte is consumed LSB first.
- R2: The descriptor occupies word addresses D..D+4, where D is the address given with the start pulse.
  - D holds the source address.
  - D+1 holds the destination address.
  - D+2 holds the length in words in bits 15:0, the check-mode bit at bit 32, the no-write bit at bit 33 and the interrupt-enable bit at bit 34.
  - D+3 holds the CRC field in bits 31:0.
  - D+4 receives the status word: bit 0 is 1 (complete), bit 1 is 1 when the CRC is valid, and all other bits are 0.
- R3: With the check-mode bit clear, the engine writes {32'b0, computed CRC} to D+3 at the end of the transfer, and the status valid bit is 1.
- R4: With the check-mode bit set, D+3 is left unchanged. The status valid bit is 1 exactly when the computed CRC equals bits 31:0 of D+3.
- R5: With the no-write bit set, no write reaches the destination region. The data is still read and checksummed.
- R6: With the no-write bit clear, destination word dst+i receives source word src+i for every i below the length.
- R7: When a check fails and the interrupt-enable bit is set, `irq_o` rises before `done_o`. It stays high until `clear_irq_i` is pulsed and drops on the next cycle. A failed check with the bit clear leaves `irq_o` low.
- R8: A length of zero makes no data reads and no data writes, and yields a CRC of 0x00000000.
- R9: `busy_o` is high from the cycle after an accepted start until the job ends. `done_o` is a one-cycle pulse in the first idle cycle, and a start pulse while busy is ignored.
- R10: Any pattern of stall cycles on `rd_ready_i` or `wr_ready_i` leaves the copied data, the CRC and the status unchanged. A request held while stalled keeps its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| desc_addr_i | input | ADDR_W | Word address of the descriptor |
| clear_irq_i | input | 1 | Clears the sticky interrupt |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | ADDR_W | Read word address |
| rd_ready_i | input | 1 | Read accepted; data valid in this same cycle |
| rd_data_i | input | 64 | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Write word address |
| wr_data_o | output | 64 | Write data |
| wr_ready_i | input | 1 | Write accepted |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| irq_o | output | 1 | Sticky check-failure interrupt |

## Verification
`busy_o` is due one cycle after the start edge, so the bench samples it at the next falling edge. All memory results are due once `done_o` pulses: the copied words, the CRC field and the status word are all written before that pulse, as is the interrupt. The bench therefore waits for `done_o` at falling edges and only then reads back memory and `irq_o`. The clear of the interrupt takes effect one cycle after the pulse and is sampled at the following falling edge. Each job is repeated with random-looking stalls on both ports, and lengths 0 to 5 are swept through six mode combinations.

// File: rtl/crc_dma_pkg.sv
package crc_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_READ, S_WRITE, S_FINISH, S_STATUS
  } dma_state_e;

  localparam int          WORD_W       = 64;
  localparam int          CRC_W        = 32;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET   = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_XOROUT   = 32'hFFFFFFFF;

  // descriptor word offsets and control bit positions
  localparam int OFS_SRC    = 0;
  localparam int OFS_DST    = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_CRC    = 3;
  localparam int OFS_STATUS = 4;
  localparam int DESC_RD    = 4;
  localparam int BIT_CHECK  = 32;
  localparam int BIT_NOWR   = 33;
  localparam int BIT_IRQEN  = 34;

  // fold one 64-bit word into a reflected CRC, bit 0 first
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c_in,
                                                input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int i = 0; i < WORD_W; i++) begin
      c = (c[0] ^ d[i]) ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/crc64_unit.sv
module crc64_unit
  import crc_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_final_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init_i)    crc_d = CRC_PRESET;
    else if (en_i) crc_d = crc_fold(crc_q, data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  assign crc_final_o = crc_q ^ CRC_XOROUT;

  // R10: a stalled beat must not disturb the running CRC
  p_crc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !en_i) |=> $stable(crc_q));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import crc_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              clear_irq_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              crc_init_o,
  output logic              crc_en_o,
  input  logic [CRC_W-1:0]  crc_final_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int DCNT_W = $clog2(DESC_RD);

  dma_state_e        state_q, state_d;
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d, cnt_inc;
  logic [ADDR_W-1:0] base_q, base_d, src_q, src_d, dst_q, dst_d;
  logic [CRC_W-1:0]  ref_q, ref_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic              check_q, check_d, nowr_q, nowr_d, irqen_q, irqen_d;
  logic              ok_q, ok_d, irq_q, irq_d, done_q, done_d;
  logic              last;

  assign cnt_inc = cnt_q + 1'b1;
  assign last    = (cnt_inc == len_q);

  always_comb begin
    state_d = state_q;  dcnt_d = dcnt_q;   cnt_d = cnt_q;   len_d = len_q;
    base_d  = base_q;   src_d  = src_q;    dst_d = dst_q;   ref_d = ref_q;
    buf_d   = buf_q;    check_d = check_q; nowr_d = nowr_q; irqen_d = irqen_q;
    ok_d    = ok_q;     irq_d  = irq_q;    done_d = 1'b0;
    rd_valid_o = 1'b0;
    rd_addr_o  = src_q + ADDR_W'(cnt_q);
    wr_valid_o = 1'b0;
    wr_addr_o  = dst_q + ADDR_W'(cnt_q);
    wr_data_o  = buf_q;
    crc_init_o = 1'b0;
    crc_en_o   = 1'b0;
    if (clear_irq_i) irq_d = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d    = S_FETCH;
          base_d     = desc_addr_i;
          dcnt_d     = '0;
          cnt_d      = '0;
          crc_init_o = 1'b1;
        end
      end
      S_FETCH: begin
        rd_valid_o = 1'b1;
        rd_addr_o  = base_q + ADDR_W'(dcnt_q);
        if (rd_ready_i) begin
          dcnt_d = dcnt_q + 1'b1;
          case (dcnt_q)
            DCNT_W'(OFS_SRC): src_d = rd_data_i[ADDR_W-1:0];
            DCNT_W'(OFS_DST): dst_d = rd_data_i[ADDR_W-1:0];
            DCNT_W'(OFS_CTRL): begin
              len_d   = rd_data_i[LEN_W-1:0];
              check_d = rd_data_i[BIT_CHECK];
              nowr_d  = rd_data_i[BIT_NOWR];
              irqen_d = rd_data_i[BIT_IRQEN];
            end
            default: begin
              ref_d   = rd_data_i[CRC_W-1:0];
              state_d = (len_q == '0) ? S_FINISH : S_READ;
            end
          endcase
        end
      end
      S_READ: begin
        rd_valid_o = 1'b1;
        if (rd_ready_i) begin
          buf_d    = rd_data_i;
          crc_en_o = 1'b1;
          if (nowr_q) begin
            cnt_d = cnt_inc;
            if (last) state_d = S_FINISH;
          end else begin
            state_d = S_WRITE;
          end
        end
      end
      S_WRITE: begin
        wr_valid_o = 1'b1;
        if (wr_ready_i) begin
          cnt_d   = cnt_inc;
          state_d = last ? S_FINISH : S_READ;
        end
      end
      S_FINISH: begin
        if (check_q) begin
          ok_d    = (crc_final_i == ref_q);
          state_d = S_STATUS;
          if ((crc_final_i != ref_q) && irqen_q) irq_d = 1'b1;
        end else begin
          wr_valid_o = 1'b1;
          wr_addr_o  = base_q + ADDR_W'(OFS_CRC);
          wr_data_o  = {{(WORD_W-CRC_W){1'b0}}, crc_final_i};
          if (wr_ready_i) begin
            ok_d    = 1'b1;
            state_d = S_STATUS;
          end
        end
      end
      default: begin
        wr_valid_o = 1'b1;
        wr_addr_o  = base_q + ADDR_W'(OFS_STATUS);
        wr_data_o  = {{(WORD_W-2){1'b0}}, ok_q, 1'b1};
        if (wr_ready_i) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; dcnt_q <= '0; cnt_q <= '0; len_q <= '0;
      base_q <= '0; src_q <= '0; dst_q <= '0; ref_q <= '0; buf_q <= '0;
      check_q <= 1'b0; nowr_q <= 1'b0; irqen_q <= 1'b0;
      ok_q <= 1'b0; irq_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; dcnt_q <= dcnt_d; cnt_q <= cnt_d; len_q <= len_d;
      base_q <= base_d; src_q <= src_d; dst_q <= dst_d; ref_q <= ref_d; buf_q <= buf_d;
      check_q <= check_d; nowr_q <= nowr_d; irqen_q <= irqen_d;
      ok_q <= ok_d; irq_q <= irq_d; done_q <= done_d;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign irq_o  = irq_q;

  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_no_dst_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && nowr_q) |-> (state_q != S_WRITE));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clear_irq_i) |=> irq_o);
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_irq_i && state_q != S_FINISH) |=> !irq_o);
endmodule

// File: rtl/crc_dma_engine.sv
module crc_dma_engine
  import crc_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  input  logic              clear_irq_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [63:0]       rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [63:0]       wr_data_o,
  input  logic              wr_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  logic              rst_n_s;
  logic              crc_init, crc_en;
  logic [CRC_W-1:0]  crc_final;

  dma_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  crc64_unit u_crc (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .init_i      (crc_init),
    .en_i        (crc_en),
    .data_i      (rd_data_i),
    .crc_final_o (crc_final)
  );

  dma_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .desc_addr_i (desc_addr_i),
    .clear_irq_i (clear_irq_i),
    .rd_valid_o  (rd_valid_o),
    .rd_addr_o   (rd_addr_o),
    .rd_ready_i  (rd_ready_i),
    .rd_data_i   (rd_data_i),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_ready_i  (wr_ready_i),
    .crc_init_o  (crc_init),
    .crc_en_o    (crc_en),
    .crc_final_i (crc_final),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/crc_dma_engine_test.sv
`timescale 1ns/1ps
module crc_dma_engine_test;
  localparam int AW = 8;
  localparam int SRC = 16;
  localparam int DST = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clr = 1'b0;
  logic [AW-1:0] daddr = '0;
  logic rd_valid, rd_ready = 1'b1, wr_valid, wr_ready = 1'b1;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0] rd_data, wr_data;
  logic busy, done, irq;
  logic [63:0] mem [0:255];
  logic [15:0] lfsr = 16'hACE1;
  logic stall = 1'b0;
  int n_chk = 0, n_bad = 0;
  int dst_wr = 0, src_rd = 0;

  always #4 clk = ~clk;

  crc_dma_engine #(.ADDR_W(AW), .LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .desc_addr_i(daddr),
    .clear_irq_i(clr), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr),
    .rd_ready_i(rd_ready), .rd_data_i(rd_data), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .busy_o(busy), .done_o(done), .irq_o(irq));

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      if (wr_addr >= DST && wr_addr < DST + 32) dst_wr <= dst_wr + 1;
    end
    if (rd_valid && rd_ready && rd_addr >= SRC && rd_addr < SRC + 32)
      src_rd <= src_rd + 1;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready <= stall ? lfsr[0] : 1'b1;
    wr_ready <= stall ? lfsr[5] : 1'b1;
  end

  function automatic logic [63:0] pat(input int i, input int seed);
    return (64'h0123_4567_89AB_CDEF * 64'(i + 1)) ^ (64'(seed) << 9) ^ 64'(i * 77);
  endfunction

  function automatic logic [31:0] ref_crc(input int n, input int seed);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < n; w++) begin
      logic [63:0] d = pat(w, seed);
      for (int b = 0; b < 8; b++) begin
        c = c ^ {24'h0, d[8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    end
    return ~c;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    if (!got) check(1'b0, "watchdog R9", 64'(busy), 64'(0));
  endtask

  // mode: 0 copy+set, 1 copy+check good, 2 copy+check bad irq,
  //       3 check-only good, 4 set no-write, 5 check-only bad no irq
  task automatic run_job(input int len, input int mode, input int seed, input bit poke);
    logic chk, nowr, irqen, bad, got;
    logic [31:0] exp;
    chk   = (mode == 1 || mode == 2 || mode == 3 || mode == 5);
    nowr  = (mode >= 3);
    irqen = (mode == 2);
    bad   = (mode == 2 || mode == 5);
    exp   = ref_crc(len, seed);
    for (int i = 0; i < 32; i++) begin
      mem[SRC + i] = pat(i, seed);
      mem[DST + i] = 64'hDEAD_0000_0000_0000 | 64'(i);
    end
    mem[0] = 64'(SRC);
    mem[1] = 64'(DST);
    mem[2] = {29'b0, irqen, nowr, chk, 16'b0, 16'(len)};
    mem[3] = chk ? {32'h1234_5678, exp ^ (bad ? 32'h0000_0100 : 32'h0)} : 64'h5555_AAAA_5555_AAAA;
    mem[4] = 64'h0;
    mem[8] = 64'h0; mem[9] = 64'h0; mem[10] = 64'h0; mem[11] = 64'h7777; mem[12] = 64'h0;
    dst_wr = 0; src_rd = 0;
    daddr = 8'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", 64'(busy), 64'(1));
    if (poke) begin
      @(negedge clk); daddr = 8'd8; start = 1'b1;
      @(negedge clk); start = 1'b0; daddr = 8'd0;
    end
    wait_done(got);
    if (!got) return;
    check(busy == 1'b0, "R9 idle at done", 64'(busy), 64'(0));
    check(mem[4] == {62'b0, !bad, 1'b1}, "R2/R4 status word", mem[4], {62'b0, !bad, 1'b1});
    if (!chk) check(mem[3] == {32'b0, exp}, "R1/R3 crc field", mem[3], {32'b0, exp});
    else check(mem[3][31:0] == (exp ^ (bad ? 32'h100 : 32'h0)), "R4 crc field kept",
               mem[3], {32'b0, exp ^ (bad ? 32'h100 : 32'h0)});
    if (len == 0) begin
      check(exp == 32'h0, "R8 empty crc", 64'(exp), 64'(0));
      check(src_rd == 0 && dst_wr == 0, "R8 no data traffic", 64'(src_rd + dst_wr), 64'(0));
    end
    if (nowr) check(dst_wr == 0, "R5 no destination write", 64'(dst_wr), 64'(0));
    for (int i = 0; i < len + 1; i++) begin
      logic [63:0] e = (!nowr && i < len) ? pat(i, seed) : (64'hDEAD_0000_0000_0000 | 64'(i));
      check(mem[DST + i] == e, nowr ? "R5 destination untouched" : "R6 copied word", mem[DST + i], e);
    end
    check(src_rd == len, "R10 read beat count", 64'(src_rd), 64'(len));
    check(irq == irqen, "R7 irq level", 64'(irq), 64'(irqen));
    if (poke) check(mem[11] == 64'h7777, "R9 start ignored while busy", mem[11], 64'h7777);
    if (irq) begin
      repeat (3) @(negedge clk);
      check(irq == 1'b1, "R7 irq sticky", 64'(irq), 64'(1));
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      check(irq == 1'b0, "R7 irq cleared", 64'(irq), 64'(0));
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", 64'(done), 64'(0));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 64'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !irq && !rd_valid && !wr_valid, "R9 reset state",
          {59'b0, busy, done, irq, rd_valid, wr_valid}, 64'h0);
    for (int s = 0; s < 2; s++) begin
      stall = s[0];
      for (int len = 0; len < 6; len++)
        for (int m = 0; m < 6; m++)
          run_job(len, m, len * 13 + m * 5 + s, (len == 4 && m == 1));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule